// File: doc/BRIEF.md
# Multi-Bank GPIO Pin Controller

This block is the register front end of a GPIO pad ring with several banks of 32 pins each. Software uses a simple single-cycle register bus to choose each pin's function, its drive strength and its pull setting. Through a per-bank data word, software also drives output levels and reads back input levels. On the pad side the block has one output value, one output enable, one drive code, one pull code and one function-select code for every pin.

Each bank takes up a 0x24-byte window, and bank n begins at byte address n × 0x24. Within a window, words 0x00–0x0C hold the function selects, 0x10 holds the data word, 0x14–0x18 hold the drive levels and 0x1C–0x20 hold the pulls. Because the window size is not a power of two, the decoder compares the address against each bank's range rather than slicing address bits.

Pad inputs pass through a two-flop synchroniser before they reach the data register or the interrupt side. Pins whose function select is 6 are flagged for interrupt routing, and their synchronised level is forwarded to the interrupt logic.

Top module: `gpio_pinbank_ctrl`

## Requirements
- R1: After reset, every function, data, drive and pull field is zero. Every pin is then an input with its output enable low, and every register reads zero while the pad inputs are low.
- R2: Bank b answers at byte addresses b×0x24 through b×0x24+0x20. A write in one bank never alters a field of another bank.
- R3: The function field of bank pin p is 4 bits wide. It lives in the word at bank offset (p div 8)×4, bits (p mod 8)×4 upward, and reads back as written. Global pin g = b×32+p drives pad_func[4g+3:4g] with it.
- R4: The data word at bank offset 0x10 holds pin p at bit p. The stored bit of global pin g appears on pad_out[g].
- R5: The drive field of pin p is 2 bits wide. It sits in the word at bank offset 0x14+(p div 16)×4, bits (p mod 16)×2 upward, and appears on pad_drive[2g+1:2g].
- R6: The pull field of pin p is 2 bits wide. It sits in the word at bank offset 0x1C+(p div 16)×4, uses the same bit placement as drive, and appears on pad_pull[2g+1:2g].
- R7: pad_oe[g] is high exactly when the pin's function field equals 1. Every other function value holds the output enable low.
- R8: irq_route[g] is high exactly when the pin's function field equals 6. irq_level[g] equals the synchronised input when the pin is routed and 0 when it is not.
- R9: A read of the data word returns the stored output bit for pins whose function is 1. For every other pin it returns the synchronised pad input.
- R10: A change on pad_in is not visible after the first rising clock edge. It becomes visible in data reads and on irq_level after the second rising edge.
- R11: A read of an address beyond the last bank, or with a nonzero value in address bits [1:0], returns zero. A write to such an address changes no field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| pad_in | input | NUM_BANKS×32 | Raw pad input levels |
| pad_out | output | NUM_BANKS×32 | Output value per pin |
| pad_oe | output | NUM_BANKS×32 | Output enable per pin |
| pad_drive | output | NUM_BANKS×64 | 2-bit drive code per pin |
| pad_pull | output | NUM_BANKS×64 | 2-bit pull code per pin |
| pad_func | output | NUM_BANKS×128 | 4-bit function select per pin |
| irq_route | output | NUM_BANKS×32 | Pin selected for interrupt function |
| irq_level | output | NUM_BANKS×32 | Synchronised level of routed pins |

## Verification
The bench aims first at the bank boundary. It writes at 0x24, the first word of bank 1, and checks that neither bank 0's last pull word nor bank 1's fields were disturbed by the wrong bank. A decoder that sliced address bits as though the stride were a power of two would land that write in the wrong bank. Next the bench moves pad inputs and samples the data read between clock edges. A synchroniser that was one flop short, or one flop too deep, would show the new level one edge early or one edge late. The bench also reads pins set to output mode while their pads are held at the opposite level, which exposes a data read that ignores the function select. Finally, it writes to addresses past the last bank and to unaligned addresses. An incomplete decode would alias those writes onto live fields, and the bench sees this on the pad outputs.

// File: rtl/gpio_pinbank_ctrl.sv
module gpio_pinbank_ctrl #(
  parameter int NUM_BANKS = 2,
  parameter int ADDR_W    = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_sel,
  input  logic                      bus_wr,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [31:0]               bus_wdata,
  output logic [31:0]               bus_rdata,
  input  logic [NUM_BANKS*32-1:0]   pad_in,
  output logic [NUM_BANKS*32-1:0]   pad_out,
  output logic [NUM_BANKS*32-1:0]   pad_oe,
  output logic [NUM_BANKS*64-1:0]   pad_drive,
  output logic [NUM_BANKS*64-1:0]   pad_pull,
  output logic [NUM_BANKS*128-1:0]  pad_func,
  output logic [NUM_BANKS*32-1:0]   irq_route,
  output logic [NUM_BANKS*32-1:0]   irq_level
);
  localparam int NP      = NUM_BANKS * 32;
  localparam int STRIDE  = 36;
  localparam int SPAN    = NUM_BANKS * STRIDE;
  localparam logic [3:0] FN_OUT = 4'd1;
  localparam logic [3:0] FN_IRQ = 4'd6;

  logic [NP*4-1:0] func_q;
  logic [NP-1:0]   dout_q;
  logic [NP*2-1:0] drv_q;
  logic [NP*2-1:0] pull_q;
  logic [NP-1:0]   sync1_q, sync2_q;
  logic [NP-1:0]   data_view;

  logic        hit;
  int unsigned bank_i;
  int unsigned word_i;
  logic [31:0] addr32;
  logic [31:0] off;

  assign addr32 = 32'(bus_addr);

  always_comb begin
    hit    = 1'b0;
    bank_i = 0;
    off    = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (addr32 >= 32'(b * STRIDE) && addr32 < 32'((b + 1) * STRIDE)) begin
        hit    = 1'b1;
        bank_i = b;
        off    = addr32 - 32'(b * STRIDE);
      end
    end
    if (bus_addr[1:0] != 2'b00) hit = 1'b0;
    word_i = 32'(off[5:2]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      func_q <= '0;
      dout_q <= '0;
      drv_q  <= '0;
      pull_q <= '0;
    end else if (bus_sel && bus_wr && hit) begin
      case (word_i)
        0, 1, 2, 3: func_q[(bank_i*4 + word_i)*32 +: 32]     <= bus_wdata;
        4:          dout_q[bank_i*32 +: 32]                  <= bus_wdata;
        5, 6:       drv_q[(bank_i*2 + word_i - 5)*32 +: 32]  <= bus_wdata;
        7, 8:       pull_q[(bank_i*2 + word_i - 7)*32 +: 32] <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pad_in;
      sync2_q <= sync1_q;
    end
  end

  for (genvar g = 0; g < NP; g++) begin : g_pin
    wire [3:0] fn = func_q[g*4 +: 4];
    assign pad_oe[g]    = (fn == FN_OUT);
    assign irq_route[g] = (fn == FN_IRQ);
    assign irq_level[g] = (fn == FN_IRQ) & sync2_q[g];
    assign data_view[g] = (fn == FN_OUT) ? dout_q[g] : sync2_q[g];
  end

  always_comb begin
    bus_rdata = '0;
    if (hit) begin
      case (word_i)
        0, 1, 2, 3: bus_rdata = func_q[(bank_i*4 + word_i)*32 +: 32];
        4:          bus_rdata = data_view[bank_i*32 +: 32];
        5, 6:       bus_rdata = drv_q[(bank_i*2 + word_i - 5)*32 +: 32];
        7, 8:       bus_rdata = pull_q[(bank_i*2 + word_i - 7)*32 +: 32];
        default:    bus_rdata = '0;
      endcase
    end
  end

  assign pad_out   = dout_q;
  assign pad_drive = drv_q;
  assign pad_pull  = pull_q;
  assign pad_func  = func_q;
endmodule

// File: rtl/gpio_pinbank_ctrl_chk.sv
module gpio_pinbank_ctrl_chk #(
  parameter int NUM_BANKS = 2,
  parameter int ADDR_W    = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      bus_sel,
  input logic                      bus_wr,
  input logic [ADDR_W-1:0]         bus_addr,
  input logic [31:0]               bus_wdata,
  input logic [NUM_BANKS*32-1:0]   pad_in,
  input logic [NUM_BANKS*32-1:0]   pad_out,
  input logic [NUM_BANKS*32-1:0]   pad_oe,
  input logic [NUM_BANKS*64-1:0]   pad_drive,
  input logic [NUM_BANKS*64-1:0]   pad_pull,
  input logic [NUM_BANKS*128-1:0]  pad_func,
  input logic [NUM_BANKS*32-1:0]   irq_route,
  input logic [NUM_BANKS*32-1:0]   irq_level
);
  localparam int NP = NUM_BANKS * 32;

  logic [NP-1:0] fn_is_out;
  logic [1:0]    cyc_q;
  logic          bad_addr;

  for (genvar g = 0; g < NP; g++) begin : g_m
    assign fn_is_out[g] = (pad_func[g*4 +: 4] == 4'd1);
  end

  assign bad_addr = (32'(bus_addr) >= 32'(NUM_BANKS * 36)) || (bus_addr[1:0] != 2'b00);

  always_ff @(posedge clk) begin
    if (!rst_n) cyc_q <= '0;
    else if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
  end

  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (pad_oe == '0 && pad_func == '0 && pad_out == '0));

  a_r7_oe_only_output: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & ~fn_is_out) == '0);

  a_r8_level_needs_route: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_level & ~irq_route) == '0);

  a_r4_data_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == ADDR_W'(16)) |=> pad_out[31:0] == $past(bus_wdata));

  a_r11_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bad_addr) |=>
      ($stable(pad_func) && $stable(pad_out) && $stable(pad_drive) && $stable(pad_pull)));

  a_r10_two_stage: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q == 2'd3 && $stable(irq_route)) |-> irq_level == ($past(pad_in, 2) & irq_route));
endmodule

bind gpio_pinbank_ctrl gpio_pinbank_ctrl_chk #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
  .pad_drive(pad_drive), .pad_pull(pad_pull), .pad_func(pad_func),
  .irq_route(irq_route), .irq_level(irq_level)
);

// File: tb/sim_gpio_pinbank_ctrl.sv
module sim_gpio_pinbank_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 2;
  localparam int NP = NB * 32;

  logic              clk = 0;
  logic              rst_n = 0;
  logic              bus_sel = 0, bus_wr = 0;
  logic [7:0]        bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic [NP-1:0]     pad_in = '0;
  logic [NP-1:0]     pad_out, pad_oe, irq_route, irq_level;
  logic [NP*2-1:0]   pad_drive, pad_pull;
  logic [NP*4-1:0]   pad_func;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_pinbank_ctrl #(.NUM_BANKS(NB), .ADDR_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .pad_drive(pad_drive), .pad_pull(pad_pull), .pad_func(pad_func),
    .irq_route(irq_route), .irq_level(irq_level)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(8'h00, v); check("R1 func word", v, 0);
    rd(8'h10, v); check("R1 data word", v, 0);
    rd(8'h40, v); check("R1 bank1 pull", v, 0);
    check("R1 oe", 32'(|pad_oe), 0);
    check("R1 func out", 32'(|pad_func), 0);
  endtask

  task automatic t_func();
    logic [31:0] v;
    wr(8'h04, 32'h7654_3210);
    rd(8'h04, v); check("R3 readback", v, 32'h7654_3210);
    check("R3 pad_func pin9", 32'(pad_func[9*4 +: 4]), 1);
    check("R7 oe pin9", 32'(pad_oe[9]), 1);
    check("R7 oe pin10 func2", 32'(pad_oe[10]), 0);
    check("R8 route pin14", 32'(irq_route[14]), 1);
    check("R8 route pin15", 32'(irq_route[15]), 0);
    wr(8'h30, 32'h1000_0000);
    check("R2 bank1 pin31 oe", 32'(pad_oe[63]), 1);
    rd(8'h0C, v); check("R2 bank0 word3 untouched", v, 0);
  endtask

  task automatic t_boundary();
    logic [31:0] v;
    wr(8'h24, 32'h0000_0001);
    check("R2 0x24 hits bank1 pin0", 32'(pad_oe[32]), 1);
    rd(8'h20, v); check("R2 bank0 pull1 untouched", v, 0);
    rd(8'h00, v); check("R2 bank0 func0 untouched", v, 0);
  endtask

  task automatic t_data();
    logic [31:0] v;
    wr(8'h34, 32'h8000_0001);
    check("R4 pad_out pin32", 32'(pad_out[32]), 1);
    check("R4 pad_out pin63", 32'(pad_out[63]), 1);
    pad_in[32] = 1'b0; pad_in[63] = 1'b0;
    rd(8'h34, v);
    check("R9 mixed modes bank1", v & 32'h8000_0003, 32'h8000_0001);
  endtask

  task automatic t_drive_pull();
    logic [31:0] v;
    wr(8'h18, 32'hC000_0003);
    check("R5 drive pin16", 32'(pad_drive[16*2 +: 2]), 3);
    check("R5 drive pin31", 32'(pad_drive[31*2 +: 2]), 3);
    check("R5 drive pin15", 32'(pad_drive[15*2 +: 2]), 0);
    wr(8'h40, 32'h0000_0008);
    check("R6 pull pin33", 32'(pad_pull[33*2 +: 2]), 2);
    rd(8'h40, v); check("R6 readback", v, 32'h0000_0008);
  endtask

  task automatic t_sync();
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = 8'h10;
    pad_in[3] = 1'b1; pad_in[14] = 1'b1; pad_in[9] = 1'b1;
    #1 check("R10 before edges", bus_rdata[3], 0);
    @(negedge clk); #1;
    check("R10 after one edge", bus_rdata[3], 0);
    check("R10 irq after one edge", 32'(irq_level[14]), 0);
    @(negedge clk); #1;
    check("R10 after two edges", bus_rdata[3], 1);
    check("R8 irq level pin14", 32'(irq_level[14]), 1);
    check("R8 irq level unrouted pin3", 32'(irq_level[3]), 0);
    check("R9 output pin9 ignores pad", bus_rdata[9], 0);
    check("R9 irq pin14 reads pad", bus_rdata[14], 1);
    bus_sel = 0;
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    logic [NP*4-1:0] f0;
    logic [NP-1:0]   o0;
    logic [NP*2-1:0] d0, p0;
    f0 = pad_func; o0 = pad_out; d0 = pad_drive; p0 = pad_pull;
    wr(8'h48, 32'hFFFF_FFFF);
    wr(8'h05, 32'hFFFF_FFFF);
    wr(8'hFC, 32'hFFFF_FFFF);
    check("R11 func unchanged", 32'(pad_func != f0), 0);
    check("R11 out unchanged", 32'(pad_out != o0), 0);
    check("R11 drive/pull unchanged", 32'((pad_drive != d0) || (pad_pull != p0)), 0);
    rd(8'h48, v); check("R11 read past end", v, 0);
    rd(8'h05, v); check("R11 read unaligned", v, 0);
    rd(8'h04, v); check("R11 neighbour intact", v, 32'h7654_3210);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_func();
    t_boundary();
    t_data();
    t_drive_pull();
    t_sync();
    t_unmapped();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule